// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Page-Load Controller

This block is the device-side control for an emulated byte-wide nonvolatile memory with a 17-bit byte address. A host drives three active-low strobes (chip enable, write enable, output enable), which are already synchronous to the system clock. The controller works out when a write cycle opens and closes, captures the address at the opening and the data at the closing, and collects bytes into a 256-byte page buffer. The page is chosen by address bits 16..8 and the byte within it by bits 7..0.

No command commits a page. Each accepted byte load restarts an inactivity window of `WIN_CYC` clock cycles. When the window runs out with no write cycle open, the controller raises `busy` and runs a programming phase of fixed length. In that phase it copies every loaded buffer entry into the storage array, one offset per cycle. It accepts no further loads until the phase ends.

The storage array holds `2**MEM_PAGE_W` pages. Higher page bits alias onto these pages. Reads return the array contents through a registered output.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: A write cycle exists only while `ce_n` and `we_n` are both 0 and `oe_n` is 1. With `oe_n` at 0, lowering `ce_n` and `we_n` loads nothing, starts no window and leaves `busy` at 0.
- R2: The address is taken in the first clock cycle in which the write condition of R1 holds, which is when the later of `ce_n`/`we_n` falls. Changing `addr` after that has no effect on where the byte goes.
- R3: The data is taken from `din` in the first cycle in which the write condition ends, which is when the earlier of `ce_n`/`we_n` rises. Changes to `din` before that cycle are overwritten.
- R4: A page is selected by `addr[16:8]` and the byte by `addr[7:0]`. One page load may hold any offsets from 0x00 to 0xFF.
- R5: While a page load is in progress, a write cycle whose `addr[16:8]` differs from the first byte's page is discarded and does not restart the window.
- R6: `busy` rises exactly `WIN_CYC` clock edges after the edge that accepted the last byte, counting that edge as 0. This holds provided no write cycle is still open at that point.
- R7: A page load has no overall length limit. A byte whose start falls on the very edge at which the window would expire is accepted, and it restarts the window.
- R8: `busy` stays at 1 for exactly max(`PROG_CYC`, 256) cycles and then returns to 0.
- R9: Write cycles while `busy` is 1 are ignored.
- R10: When the same offset is loaded twice in one page load, the array receives the later value.
- R11: With `ce_n` and `oe_n` at 0, `dout` shows, one clock later, the array byte at page `addr[8+MEM_PAGE_W-1:8]` and offset `addr[7:0]`. Page bits above that alias.
- R12: Offsets not loaded in a page load keep their previous array contents.
- R13: After reset, `busy` is 0 and every array byte, together with `dout`, reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, clock-synchronous |
| we_n | input | 1 | Write enable, active low, clock-synchronous |
| oe_n | input | 1 | Output enable, active low, clock-synchronous |
| addr | input | 17 | Byte address; bits 16..8 page, 7..0 offset |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| busy | output | 1 | High during the programming phase |

## Verification
Window expiry and the start of a new byte load can land on the same clock edge. The bench provokes this by placing a write start exactly `WIN_CYC` edges after the previous accepted start. The load must win: `busy` stays 0 on the next sample and rises only `WIN_CYC` edges after the late byte, and that byte appears in the array. A second collision, a page mismatch arriving inside the window, is timed so that the expected rise of `busy` tells apart a restarted window from an unrestarted one.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int ADDR_W     = 17;
    localparam int OFF_W      = 8;
    localparam int PAGE_W     = ADDR_W - OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int DATA_W     = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic start;
        logic done;
        logic rd_en;
    } strobe_evt_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/eep_strobe.sv
module eep_strobe
    import eep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    output strobe_evt_t evt
);
    logic wr_now;
    logic wr_prev;

    // write condition opens on the later falling strobe, closes on the earlier rise
    assign wr_now = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b0;
        else     wr_prev <= wr_now;
    end

    always_comb begin
        evt.start = wr_now && !wr_prev;
        evt.done  = !wr_now && wr_prev;
        evt.rd_en = !ce_n && !oe_n;
    end
endmodule

// File: rtl/eep_load_ctrl.sv
module eep_load_ctrl
    import eep_pkg::*;
#(
    parameter int WIN_CYC  = 25000,
    parameter int PROG_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_evt_t       evt,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              loading,
    output logic              acc_start,
    output logic              buf_we,
    output logic [OFF_W-1:0]  buf_off,
    output logic [PAGE_W-1:0] cur_page,
    output logic              copy_en,
    output logic [OFF_W-1:0]  copy_idx,
    output logic              clr_valid
);
    localparam int PROG_LEN = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES;
    localparam int TMR_W    = $clog2(WIN_CYC + 1);
    localparam int CNT_W    = $clog2(PROG_LEN + 1);

    ld_state_e         st;
    logic [TMR_W-1:0]  tmr;
    logic [CNT_W-1:0]  cnt;
    logic              open_q;
    logic              same_page;
    logic              expired;
    logic              prog_last;

    assign same_page = (page_of(addr) == cur_page);
    assign acc_start = evt.start &&
                       ((st == ST_IDLE) || ((st == ST_LOAD) && same_page));
    assign expired   = (tmr >= TMR_W'(WIN_CYC - 1)) && !open_q;
    assign prog_last = (cnt == CNT_W'(PROG_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tmr      <= '0;
            cnt      <= '0;
            open_q   <= 1'b0;
            cur_page <= '0;
            buf_off  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (acc_start) begin
                        cur_page <= page_of(addr);
                        buf_off  <= off_of(addr);
                        open_q   <= 1'b1;
                        tmr      <= '0;
                        st       <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (acc_start) begin
                        // a new load wins over an expiring window
                        buf_off <= off_of(addr);
                        open_q  <= 1'b1;
                        tmr     <= '0;
                    end else begin
                        if (evt.done) open_q <= 1'b0;
                        if (expired) begin
                            st  <= ST_PROG;
                            cnt <= '0;
                        end else if (tmr < TMR_W'(WIN_CYC - 1)) begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (prog_last) st <= ST_IDLE;
                    cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st == ST_PROG);
    assign loading   = (st == ST_LOAD);
    assign buf_we    = evt.done && open_q;
    assign copy_en   = busy && (cnt < CNT_W'(PAGE_BYTES));
    assign copy_idx  = cnt[OFF_W-1:0];
    assign clr_valid = busy && prog_last;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OFF_W-1:0]  woff,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr,
    input  logic [OFF_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0]     mem [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;

    always_ff @(posedge clk) begin
        if (we) mem[woff] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) vld <= '0;
        else if (we)    vld[woff] <= 1'b1;
    end

    assign rdata  = mem[ridx];
    assign rvalid = vld[ridx];
endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int MEM_PAGE_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [MEM_PAGE_W+OFF_W-1:0] waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        re,
    input  logic [MEM_PAGE_W+OFF_W-1:0] raddr,
    output logic [DATA_W-1:0]           rdata
);
    localparam int DEPTH = 1 << (MEM_PAGE_W + OFF_W);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
    import eep_pkg::*;
#(
    parameter int WIN_CYC    = 25000,
    parameter int PROG_CYC   = 1250000,
    parameter int MEM_PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);
    localparam int PROG_LEN = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES;
    localparam int ARR_AW   = MEM_PAGE_W + OFF_W;

    strobe_evt_t        evt;
    logic               loading;
    logic               acc_start;
    logic               buf_we;
    logic [OFF_W-1:0]   buf_off;
    logic [PAGE_W-1:0]  cur_page;
    logic               copy_en;
    logic [OFF_W-1:0]   copy_idx;
    logic               clr_valid;
    logic [DATA_W-1:0]  buf_rdata;
    logic               buf_rvalid;
    logic               arr_we;
    logic [ARR_AW-1:0]  arr_waddr;
    logic [ARR_AW-1:0]  arr_raddr;

    eep_strobe u_strobe (
        .clk (clk),
        .rst (rst),
        .ce_n(ce_n),
        .we_n(we_n),
        .oe_n(oe_n),
        .evt (evt)
    );

    eep_load_ctrl #(
        .WIN_CYC (WIN_CYC),
        .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr     (addr),
        .busy     (busy),
        .loading  (loading),
        .acc_start(acc_start),
        .buf_we   (buf_we),
        .buf_off  (buf_off),
        .cur_page (cur_page),
        .copy_en  (copy_en),
        .copy_idx (copy_idx),
        .clr_valid(clr_valid)
    );

    eep_page_buf u_buf (
        .clk   (clk),
        .rst   (rst),
        .we    (buf_we),
        .woff  (buf_off),
        .wdata (din),
        .clr   (clr_valid),
        .ridx  (copy_idx),
        .rdata (buf_rdata),
        .rvalid(buf_rvalid)
    );

    assign arr_we    = copy_en && buf_rvalid;
    assign arr_waddr = {cur_page[MEM_PAGE_W-1:0], copy_idx};
    assign arr_raddr = {addr[OFF_W+MEM_PAGE_W-1:OFF_W], addr[OFF_W-1:0]};

    generate
        if (MEM_PAGE_W < PAGE_W) begin : g_alias
            logic unused_hi;
            assign unused_hi = ^{addr[ADDR_W-1:OFF_W+MEM_PAGE_W],
                                 cur_page[PAGE_W-1:MEM_PAGE_W], loading, acc_start};
        end else begin : g_full
            logic unused_hi;
            assign unused_hi = ^{loading, acc_start};
        end
    endgenerate

    eep_array #(
        .MEM_PAGE_W(MEM_PAGE_W)
    ) u_arr (
        .clk  (clk),
        .rst  (rst),
        .we   (arr_we),
        .waddr(arr_waddr),
        .wdata(buf_rdata),
        .re   (evt.rd_en),
        .raddr(arr_raddr),
        .rdata(dout)
    );
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
    parameter int WIN_CYC  = 16,
    parameter int PROG_LEN = 256
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic loading,
    input logic acc_start,
    input logic buf_we,
    input logic arr_we
);
    int busy_run;
    int gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= 0;
            gap      <= 0;
        end else begin
            busy_run <= busy ? busy_run + 1 : 0;
            if (acc_start)          gap <= 0;
            else if (gap < WIN_CYC + 4) gap <= gap + 1;
        end
    end

    AST_BUSY_RUN_MAX: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < PROG_LEN));                              // R8
    AST_BUSY_RUN_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == PROG_LEN));                      // R8
    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !buf_we);                                            // R9
    AST_ARRAY_ONLY_PROG: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);                                             // R12
    AST_WINDOW_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (gap >= WIN_CYC));                            // R6
    AST_START_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        acc_start |=> !busy);                                         // R7
    AST_PROG_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(loading));                              // R6
endmodule

bind eeprom_page_ctrl eep_chk #(
    .WIN_CYC (WIN_CYC),
    .PROG_LEN(PROG_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .loading  (loading),
    .acc_start(acc_start),
    .buf_we   (buf_we),
    .arr_we   (arr_we)
);

// File: tb/sim_eeprom_page_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_page_ctrl;
    localparam int WIN  = 40;
    localparam int PROG = 300;
    localparam int MPW  = 3;
    localparam int PLEN = (PROG > 256) ? PROG : 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] mdl [1 << (MPW + 8)];

    // stimulus table: {addr, data}, all page 0x003; offset 0x10 loaded twice
    localparam logic [24:0] VEC [8] = '{
        {17'h00300, 8'hA5}, {17'h00301, 8'h3C}, {17'h003FF, 8'h81},
        {17'h00310, 8'h11}, {17'h00355, 8'h7E}, {17'h00310, 8'h22},
        {17'h00380, 8'hF0}, {17'h00302, 8'h09}
    };

    eeprom_page_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PROG), .MEM_PAGE_W(MPW)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int midx(input logic [16:0] a);
        return int'({a[8+MPW-1:8], a[7:0]});
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // caller stands at a negedge; the start edge is the next posedge
    task automatic wr_byte(input logic [16:0] a, input logic [7:0] d, output int s);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); s = cyc;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input logic [16:0] a, input logic [7:0] exp, input string req);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        chk(req, int'(dout), int'(exp));
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // checks the timeout edge after start s and the programming length
    task automatic timeout_and_prog(input int s, input string req, input bit poke);
        int r;
        int dummy;
        wait_cyc(s + WIN - 1);
        chk({req, " busy low before window end"}, int'(busy), 0);
        @(negedge clk);
        chk({req, " busy high at window end"}, int'(busy), 1);
        r = cyc;
        if (poke) wr_byte(17'h00304, 8'h99, dummy);   // R9: ignored while busy
        while (busy) @(negedge clk);
        chk("R8 programming length", cyc - r, PLEN);
    endtask

    initial begin
        int s;
        for (int i = 0; i < (1 << (MPW + 8)); i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R13 busy after reset", int'(busy), 0);
        chk("R13 dout after reset", int'(dout), 0);
        rd_chk(17'h00123, 8'h00, "R13 array cleared");

        // table walk: one page load, R4 and R10
        s = 0;
        for (int i = 0; i < 8; i++) begin
            wr_byte(VEC[i][24:8], VEC[i][7:0], s);
            mdl[midx(VEC[i][24:8])] = VEC[i][7:0];
        end
        timeout_and_prog(s, "R6", 1'b1);
        for (int i = 0; i < 8; i++)
            rd_chk(VEC[i][24:8], mdl[midx(VEC[i][24:8])], "R4/R10 table readback");
        rd_chk(17'h00310, 8'h22, "R10 later value kept");
        rd_chk(17'h00304, 8'h00, "R9 write during busy ignored");
        rd_chk(17'h00B00, 8'hA5, "R11 page alias read");

        // R1: output enable low blocks writing
        addr = 17'h00305; din = 8'h55; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (WIN + 5) @(negedge clk);
        chk("R1 no window after oe-low write", int'(busy), 0);
        rd_chk(17'h00305, 8'h00, "R1 oe-low write discarded");

        // R2/R3: write-enable first, chip-enable later; addr and din change mid-cycle
        addr = 17'h00520; din = 8'h44; we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk); s = cyc;
        addr = 17'h00521; din = 8'h77;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        // R5: other page inside window, must not restart it
        begin
            int s2;
            wait_cyc(s + 9);
            wr_byte(17'h00630, 8'h66, s2);
        end
        timeout_and_prog(s, "R5", 1'b0);
        rd_chk(17'h00520, 8'h77, "R2/R3 address at open, data at close");
        rd_chk(17'h00521, 8'h00, "R2 late address unused");
        rd_chk(17'h00630, 8'h00, "R5 mismatched page discarded");

        // R7: long load with spaced bytes, last one on the expiry edge
        begin
            int prev;
            wr_byte(17'h00710, 8'hC1, prev);
            wait_cyc(prev + WIN - 5);
            wr_byte(17'h00711, 8'hC2, prev);
            wait_cyc(prev + WIN - 5);
            wr_byte(17'h00712, 8'hC3, prev);
            wait_cyc(prev + WIN - 1);
            chk("R7 busy low before boundary byte", int'(busy), 0);
            wr_byte(17'h00713, 8'hC4, s);
            chk("R7 boundary start edge", s, prev + WIN);
            chk("R7 boundary byte wins over expiry", int'(busy), 0);
        end
        timeout_and_prog(s, "R7", 1'b0);
        rd_chk(17'h00710, 8'hC1, "R7 first byte");
        rd_chk(17'h00712, 8'hC3, "R7 middle byte");
        rd_chk(17'h00713, 8'hC4, "R7 boundary byte");

        // R12: reload one byte of page 3, neighbours keep contents
        wr_byte(17'h00301, 8'h5A, s);
        timeout_and_prog(s, "R12", 1'b0);
        rd_chk(17'h00301, 8'h5A, "R12 reloaded byte");
        rd_chk(17'h00300, 8'hA5, "R12 untouched byte kept");
        rd_chk(17'h003FF, 8'h81, "R12 untouched last offset kept");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule